// File: doc/BRIEF.md
# SPI Controller Register and Interrupt Front End

This block is the register-facing side of a command-driven SPI controller. A host reaches it through a simple word-addressed register port with a valid/ready handshake. Through that port the host reads an identification word, holds or releases the engine with a soft-reset bit, and manages four interrupt sources through enable, pending and masked-source registers. It also reads back the ID of the last completed sync event, sees how much room is left in the command and transmit FIFOs and how full the receive FIFO is, pushes command and transmit words, and pops or peeks received words.

The SPI sequencer sits on the other side. It drains the command and transmit FIFOs, fills the receive FIFO, and reports sync events that carry an 8-bit ID. Three interrupt sources are level watermarks on the FIFOs. The fourth is a latched flag that a sync event sets and a host write clears. The single interrupt output is the OR of every pending source whose enable bit is set.

The register port is handled by a two-state machine. In `BUS_IDLE` the block waits for a request. A valid request is performed at the next clock edge (transition IDLE→ACK), and the state moves to `BUS_ACK`. In `BUS_ACK` the ready strobe is high for one cycle with the read data. The state then returns unconditionally to `BUS_IDLE` (transition ACK→IDLE), and the request valid is ignored for that cycle.

Top module: `spi_ctrl_regfile`

## Requirements
- R1: A read at byte offset 0x00 returns the identification word: bits [31:24] are 0, bits [23:16] hold the major number 1, bits [15:8] hold parameter VER_MINOR (default 0x03) and bits [7:0] hold parameter VER_PATCH (default 0x61). With the defaults the word is 0x00010361.
- R2: Bit 0 of offset 0x40 is the soft-reset control. It reads back the last value written and is 1 after a hardware reset. While it is 1, `engine_rst` is high, all three FIFOs are held empty, and pushes from either side are dropped. Writing 0 releases the engine and the FIFOs.
- R3: Reads at 0xD0 and 0xD4 return the number of free entries in the command FIFO and the transmit FIFO. A read at 0xD8 returns the number of filled entries in the receive FIFO.
- R4: A write to 0xE0 pushes the low CMD_W bits of the write data into the command FIFO. A write to 0xE4 pushes the full data word into the transmit FIFO. The sequencer side presents these words in first-in, first-out order. A push into a full FIFO is dropped and leaves the FIFO contents and count unchanged.
- R5: A read at 0xE8 returns the receive FIFO head and removes it. A read at 0xEC returns the same head without removing it. On an empty receive FIFO, either read returns 0 and the level stays 0.
- R6: Offset 0x84 reads the pending bits. Bit 0 is 1 while the command FIFO count is at most CMD_AE. Bit 1 is 1 while the transmit FIFO count is at most TX_AE. Bit 2 is 1 while the receive FIFO count is at least RX_AF. These three bits follow the FIFO counts directly and are never latched.
- R7: A sync event stores its 8-bit ID, which reads back at 0xC0, and sets pending bit 3. Writing a 1 to bit 3 at 0x84 clears that bit. Writes to 0x84 have no effect on bits 0 to 2. If a sync event and a clear arrive in the same cycle, the set wins.
- R8: Bits [3:0] of 0x80 are the interrupt enables and reset to 0. A read at 0x88 returns pending AND enable. `irq` is high exactly when that masked value is nonzero.
- R9: Each accepted request raises `resp_ready` for exactly one cycle, in the cycle after acceptance. Reads of unmapped offsets return 0. Writes to unmapped or read-only offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; bits [1:0] are ignored |
| req_wdata | input | DATA_W | Write data |
| resp_ready | output | 1 | One-cycle completion strobe |
| resp_rdata | output | DATA_W | Read data, valid while `resp_ready` is high |
| seq_cmd_valid | output | 1 | Command FIFO is not empty |
| seq_cmd_data | output | CMD_W | Command FIFO head |
| seq_cmd_pop | input | 1 | Removes the command FIFO head |
| seq_tx_valid | output | 1 | Transmit FIFO is not empty |
| seq_tx_data | output | DATA_W | Transmit FIFO head |
| seq_tx_pop | input | 1 | Removes the transmit FIFO head |
| seq_rx_ready | output | 1 | Receive FIFO is not full |
| seq_rx_push | input | 1 | Pushes a received word |
| seq_rx_data | input | DATA_W | Received word |
| seq_sync_evt | input | 1 | Sync event completion strobe |
| seq_sync_id | input | 8 | ID carried by the sync event |
| engine_rst | output | 1 | Soft reset to the sequencer |
| irq | output | 1 | Level interrupt |

## Verification
The command FIFO is filled past capacity with words whose upper bits are junk. Draining it then shows both the truncation to CMD_W bits and the dropping of the overflow word, which a wrapping pointer would instead have overwritten. On the receive side, peek and pop reads are interleaved, and both are also read while the FIFO is empty; this separates a destructive peek from a correct one and shows whether the count underflows. The watermark bits are compared with FIFO counts on both sides of each threshold, and the pending register is written with all ones, to show that those bits follow the counts and cannot be cleared. Sync events with distinct IDs are cleared both by a single-bit write and by an all-ones write, to tie the latched flag, the ID and `irq` to the enable mask.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_ACK  = 1'b1
    } bus_state_t;

    // word indices (byte offset >> 2)
    localparam logic [5:0] WI_IDENT    = 6'h00;
    localparam logic [5:0] WI_SOFTRST  = 6'h10;
    localparam logic [5:0] WI_IRQ_EN   = 6'h20;
    localparam logic [5:0] WI_IRQ_PEND = 6'h21;
    localparam logic [5:0] WI_IRQ_SRC  = 6'h22;
    localparam logic [5:0] WI_SYNC_ID  = 6'h30;
    localparam logic [5:0] WI_CMD_ROOM = 6'h34;
    localparam logic [5:0] WI_TX_ROOM  = 6'h35;
    localparam logic [5:0] WI_RX_LVL   = 6'h36;
    localparam logic [5:0] WI_CMD_PUSH = 6'h38;
    localparam logic [5:0] WI_TX_PUSH  = 6'h39;
    localparam logic [5:0] WI_RX_POP   = 6'h3A;
    localparam logic [5:0] WI_RX_PEEK  = 6'h3B;

    localparam int NUM_IRQ = 4;
    localparam int IB_CMD  = 0;
    localparam int IB_TX   = 1;
    localparam int IB_RX   = 2;
    localparam int IB_SYNC = 3;

endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign head    = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + AW'(1);
            if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // R4
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> $stable(count));

    // R5
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !clr) |=> (count == '0));

    // R2
    clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));

    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

endmodule

// File: rtl/spi_irq_unit.sv
module spi_irq_unit
    import spi_regs_pkg::*;
#(
    parameter int CCW    = 5,
    parameter int TCW    = 5,
    parameter int RCW    = 5,
    parameter int CMD_AE = 4,
    parameter int TX_AE  = 4,
    parameter int RX_AF  = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CCW-1:0]     cmd_count,
    input  logic [TCW-1:0]     tx_count,
    input  logic [RCW-1:0]     rx_count,
    input  logic               sync_evt,
    input  logic [7:0]         sync_id_in,
    input  logic               pend_wr,
    input  logic [NUM_IRQ-1:0] pend_wmask,
    input  logic               en_wr,
    input  logic [NUM_IRQ-1:0] en_wdata,
    output logic [NUM_IRQ-1:0] pending,
    output logic [NUM_IRQ-1:0] enable,
    output logic [NUM_IRQ-1:0] source,
    output logic [7:0]         sync_id,
    output logic               irq
);

    logic sync_flag;

    always_comb begin
        pending          = '0;
        pending[IB_CMD]  = (cmd_count <= CCW'(CMD_AE));
        pending[IB_TX]   = (tx_count  <= TCW'(TX_AE));
        pending[IB_RX]   = (rx_count  >= RCW'(RX_AF));
        pending[IB_SYNC] = sync_flag;
    end

    assign source = pending & enable;
    assign irq    = |source;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_flag <= 1'b0;
            sync_id   <= '0;
            enable    <= '0;
        end else begin
            if (en_wr) enable <= en_wdata;
            if (sync_evt) begin
                sync_flag <= 1'b1;
                sync_id   <= sync_id_in;
            end else if (pend_wr && pend_wmask[IB_SYNC]) begin
                sync_flag <= 1'b0;
            end
        end
    end

    // R7
    sync_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_evt |=> (pending[IB_SYNC] && sync_id == $past(sync_id_in)));

    // R7
    sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_wr && pend_wmask[IB_SYNC] && !sync_evt) |=> !pending[IB_SYNC]);

    // R8
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable == '0) |-> !irq);

endmodule

// File: rtl/spi_ctrl_regfile.sv
module spi_ctrl_regfile
    import spi_regs_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int CMD_W     = 16,
    parameter int CMD_DEPTH = 16,
    parameter int TX_DEPTH  = 16,
    parameter int RX_DEPTH  = 16,
    parameter int CMD_AE    = 4,
    parameter int TX_AE     = 4,
    parameter int RX_AF     = 12,
    parameter logic [7:0] VER_MINOR = 8'h03,
    parameter logic [7:0] VER_PATCH = 8'h61
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              resp_ready,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              seq_cmd_valid,
    output logic [CMD_W-1:0]  seq_cmd_data,
    input  logic              seq_cmd_pop,
    output logic              seq_tx_valid,
    output logic [DATA_W-1:0] seq_tx_data,
    input  logic              seq_tx_pop,
    output logic              seq_rx_ready,
    input  logic              seq_rx_push,
    input  logic [DATA_W-1:0] seq_rx_data,
    input  logic              seq_sync_evt,
    input  logic [7:0]        seq_sync_id,
    output logic              engine_rst,
    output logic              irq
);

    localparam int CCW = $clog2(CMD_DEPTH + 1);
    localparam int TCW = $clog2(TX_DEPTH + 1);
    localparam int RCW = $clog2(RX_DEPTH + 1);
    localparam logic [7:0] VER_MAJOR = 8'h01;

    bus_state_t state, state_nx;

    logic [5:0]         widx;
    logic               accept, wr_acc, rd_acc;
    logic               cmd_push, tx_push, rx_pop, en_wr, pend_wr, rst_wr;
    logic               soft_rst;
    logic [DATA_W-1:0]  rd_mux;

    logic [CCW-1:0]     cmd_count;
    logic [TCW-1:0]     tx_count;
    logic [RCW-1:0]     rx_count;
    logic               cmd_full, cmd_empty, tx_full, tx_empty, rx_full, rx_empty;
    logic [DATA_W-1:0]  rx_head;

    logic [NUM_IRQ-1:0] pending, enable, source;
    logic [7:0]         sync_id;

    // ---------------- bus state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= BUS_IDLE;
        else        state <= state_nx;
    end

    // ---------------- next state and access strobes ----------------
    always_comb begin
        state_nx   = state;
        resp_ready = 1'b0;
        accept     = 1'b0;
        unique case (state)
            BUS_IDLE: begin
                if (req_valid) begin
                    accept   = 1'b1;
                    state_nx = BUS_ACK;
                end
            end
            BUS_ACK: begin
                resp_ready = 1'b1;
                state_nx   = BUS_IDLE;
            end
        endcase
    end

    assign widx     = req_addr[7:2];
    assign wr_acc   = accept && req_write;
    assign rd_acc   = accept && !req_write;
    assign cmd_push = wr_acc && (widx == WI_CMD_PUSH);
    assign tx_push  = wr_acc && (widx == WI_TX_PUSH);
    assign en_wr    = wr_acc && (widx == WI_IRQ_EN);
    assign pend_wr  = wr_acc && (widx == WI_IRQ_PEND);
    assign rst_wr   = wr_acc && (widx == WI_SOFTRST);
    assign rx_pop   = rd_acc && (widx == WI_RX_POP);

    // ---------------- read mux ----------------
    always_comb begin
        unique case (widx)
            WI_IDENT:    rd_mux = DATA_W'({8'h00, VER_MAJOR, VER_MINOR, VER_PATCH});
            WI_SOFTRST:  rd_mux = DATA_W'(soft_rst);
            WI_IRQ_EN:   rd_mux = DATA_W'(enable);
            WI_IRQ_PEND: rd_mux = DATA_W'(pending);
            WI_IRQ_SRC:  rd_mux = DATA_W'(source);
            WI_SYNC_ID:  rd_mux = DATA_W'(sync_id);
            WI_CMD_ROOM: rd_mux = DATA_W'(CCW'(CMD_DEPTH) - cmd_count);
            WI_TX_ROOM:  rd_mux = DATA_W'(TCW'(TX_DEPTH) - tx_count);
            WI_RX_LVL:   rd_mux = DATA_W'(rx_count);
            WI_RX_POP,
            WI_RX_PEEK:  rd_mux = rx_head;
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_rdata <= '0;
            soft_rst   <= 1'b1;
        end else begin
            if (rd_acc) resp_rdata <= rd_mux;
            if (rst_wr) soft_rst   <= req_wdata[0];
        end
    end

    assign engine_rst = soft_rst;

    // ---------------- FIFOs ----------------
    spi_word_fifo #(.W(CMD_W), .DEPTH(CMD_DEPTH)) u_cmd_fifo (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst),
        .push(cmd_push), .wdata(req_wdata[CMD_W-1:0]),
        .pop(seq_cmd_pop), .head(seq_cmd_data), .count(cmd_count),
        .full(cmd_full), .empty(cmd_empty)
    );

    spi_word_fifo #(.W(DATA_W), .DEPTH(TX_DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst),
        .push(tx_push), .wdata(req_wdata),
        .pop(seq_tx_pop), .head(seq_tx_data), .count(tx_count),
        .full(tx_full), .empty(tx_empty)
    );

    spi_word_fifo #(.W(DATA_W), .DEPTH(RX_DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst),
        .push(seq_rx_push), .wdata(seq_rx_data),
        .pop(rx_pop), .head(rx_head), .count(rx_count),
        .full(rx_full), .empty(rx_empty)
    );

    assign seq_cmd_valid = !cmd_empty;
    assign seq_tx_valid  = !tx_empty;
    assign seq_rx_ready  = !rx_full;

    // ---------------- interrupts ----------------
    spi_irq_unit #(
        .CCW(CCW), .TCW(TCW), .RCW(RCW),
        .CMD_AE(CMD_AE), .TX_AE(TX_AE), .RX_AF(RX_AF)
    ) u_irq (
        .clk(clk), .rst_n(rst_n),
        .cmd_count(cmd_count), .tx_count(tx_count), .rx_count(rx_count),
        .sync_evt(seq_sync_evt), .sync_id_in(seq_sync_id),
        .pend_wr(pend_wr), .pend_wmask(req_wdata[NUM_IRQ-1:0]),
        .en_wr(en_wr), .en_wdata(req_wdata[NUM_IRQ-1:0]),
        .pending(pending), .enable(enable), .source(source),
        .sync_id(sync_id), .irq(irq)
    );

    // R9
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_ready |=> !resp_ready);

    // R9
    accept_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BUS_IDLE && req_valid) |=> resp_ready);

    // R2
    hold_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        engine_rst |=> (!seq_cmd_valid && !seq_tx_valid));

endmodule

// File: tb/test_spi_ctrl_regfile.sv
`timescale 1ns/1ps
module test_spi_ctrl_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        resp_ready;
    logic [31:0] resp_rdata;
    logic        seq_cmd_valid, seq_tx_valid, seq_rx_ready;
    logic [15:0] seq_cmd_data;
    logic [31:0] seq_tx_data;
    logic        seq_cmd_pop = 1'b0, seq_tx_pop = 1'b0, seq_rx_push = 1'b0;
    logic [31:0] seq_rx_data = '0;
    logic        seq_sync_evt = 1'b0;
    logic [7:0]  seq_sync_id = '0;
    logic        engine_rst, irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    spi_ctrl_regfile i_spi_ctrl_regfile (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .resp_ready(resp_ready), .resp_rdata(resp_rdata),
        .seq_cmd_valid(seq_cmd_valid), .seq_cmd_data(seq_cmd_data), .seq_cmd_pop(seq_cmd_pop),
        .seq_tx_valid(seq_tx_valid), .seq_tx_data(seq_tx_data), .seq_tx_pop(seq_tx_pop),
        .seq_rx_ready(seq_rx_ready), .seq_rx_push(seq_rx_push), .seq_rx_data(seq_rx_data),
        .seq_sync_evt(seq_sync_evt), .seq_sync_id(seq_sync_id),
        .engine_rst(engine_rst), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        chk("R9 ready after write", 32'(resp_ready), 32'd1);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        chk("R9 ready after read", 32'(resp_ready), 32'd1);
        d = resp_rdata;
        req_valid = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic seq_pop_cmd();
        @(negedge clk); seq_cmd_pop = 1'b1;
        @(negedge clk); seq_cmd_pop = 1'b0;
    endtask

    task automatic seq_push_rx(input logic [31:0] d);
        @(negedge clk); seq_rx_push = 1'b1; seq_rx_data = d;
        @(negedge clk); seq_rx_push = 1'b0;
    endtask

    task automatic seq_sync(input logic [7:0] id);
        @(negedge clk); seq_sync_evt = 1'b1; seq_sync_id = id;
        @(negedge clk); seq_sync_evt = 1'b0;
    endtask

    task automatic t_reset_state();
        rd_chk("R1 ident word", 8'h00, 32'h0001_0361);
        rd_chk("R2 softrst reads 1", 8'h40, 32'd1);
        chk("R2 engine_rst held", 32'(engine_rst), 32'd1);
        chk("R8 irq low at reset", 32'(irq), 32'd0);
        rd_chk("R8 enable resets 0", 8'h80, 32'd0);
        bus_wr(8'hE0, 32'h1234);
        rd_chk("R2 push dropped while held", 8'hD0, 32'd16);
        bus_wr(8'h40, 32'd0);
        rd_chk("R2 softrst readback 0", 8'h40, 32'd0);
        chk("R2 engine released", 32'(engine_rst), 32'd0);
        // single-cycle ready: a cycle after a completed access it is low
        @(negedge clk);
        chk("R9 ready one cycle", 32'(resp_ready), 32'd0);
    endtask

    task automatic t_rooms();
        rd_chk("R3 cmd room empty", 8'hD0, 32'd16);
        rd_chk("R3 tx room empty", 8'hD4, 32'd16);
        rd_chk("R3 rx level empty", 8'hD8, 32'd0);
    endtask

    task automatic t_cmd_fill();
        for (int i = 0; i < 17; i++) bus_wr(8'hE0, 32'hABCD_1000 + 32'(i));
        rd_chk("R4 cmd full room 0", 8'hD0, 32'd0);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            chk("R4 cmd valid", 32'(seq_cmd_valid), 32'd1);
            chk("R4 cmd order", 32'(seq_cmd_data), 32'h1000 + 32'(i));
            seq_pop_cmd();
        end
        @(negedge clk);
        chk("R4 overflow word dropped", 32'(seq_cmd_valid), 32'd0);
        rd_chk("R3 cmd room after drain", 8'hD0, 32'd16);
    endtask

    task automatic t_tx();
        bus_wr(8'hE4, 32'hDEAD_0001);
        bus_wr(8'hE4, 32'hDEAD_0002);
        bus_wr(8'hE4, 32'hDEAD_0003);
        rd_chk("R3 tx room 13", 8'hD4, 32'd13);
        chk("R4 tx head", seq_tx_data, 32'hDEAD_0001);
    endtask

    task automatic t_rx();
        rd_chk("R5 empty pop 0", 8'hE8, 32'd0);
        rd_chk("R5 empty peek 0", 8'hEC, 32'd0);
        rd_chk("R5 no underflow", 8'hD8, 32'd0);
        seq_push_rx(32'hA0); seq_push_rx(32'hA1); seq_push_rx(32'hA2);
        rd_chk("R3 rx level 3", 8'hD8, 32'd3);
        rd_chk("R5 peek head", 8'hEC, 32'hA0);
        rd_chk("R5 peek keeps level", 8'hD8, 32'd3);
        rd_chk("R5 pop head", 8'hE8, 32'hA0);
        rd_chk("R5 pop lowers level", 8'hD8, 32'd2);
        rd_chk("R5 peek next", 8'hEC, 32'hA1);
    endtask

    task automatic t_watermarks();
        // cmd 0 (<=4), tx 3 (<=4), rx 2 (<12)
        rd_chk("R6 pending cmd+tx", 8'h84, 32'h3);
        bus_wr(8'hE4, 32'd4); bus_wr(8'hE4, 32'd5);
        rd_chk("R6 tx above mark", 8'h84, 32'h1);
        bus_wr(8'h84, 32'hFF);
        rd_chk("R7 watermarks not clearable", 8'h84, 32'h1);
        for (int i = 0; i < 10; i++) seq_push_rx(32'(i));
        rd_chk("R6 rx at mark", 8'h84, 32'h5);
        bus_wr(8'h80, 32'h2);
        chk("R8 masked irq low", 32'(irq), 32'd0);
        rd_chk("R8 source masked", 8'h88, 32'h0);
        bus_wr(8'h80, 32'h4);
        chk("R8 rx irq", 32'(irq), 32'd1);
        rd_chk("R8 source rx", 8'h88, 32'h4);
        bus_wr(8'h80, 32'h0);
        chk("R8 irq off", 32'(irq), 32'd0);
    endtask

    task automatic t_sync();
        seq_sync(8'h5A);
        rd_chk("R7 sync id", 8'hC0, 32'h5A);
        rd_chk("R7 sync pending", 8'h84, 32'hD);
        bus_wr(8'h80, 32'h8);
        chk("R8 sync irq", 32'(irq), 32'd1);
        rd_chk("R8 source sync", 8'h88, 32'h8);
        bus_wr(8'h84, 32'h8);
        rd_chk("R7 sync cleared", 8'h84, 32'h5);
        chk("R8 irq after clear", 32'(irq), 32'd0);
        seq_sync(8'hC3);
        rd_chk("R7 second id", 8'hC0, 32'hC3);
        bus_wr(8'h84, 32'hFF);
        rd_chk("R7 all-ones clear", 8'h84, 32'h5);
        bus_wr(8'h80, 32'h0);
    endtask

    task automatic t_soft_reset();
        bus_wr(8'h40, 32'd1);
        chk("R2 engine_rst asserted", 32'(engine_rst), 32'd1);
        rd_chk("R2 tx flushed", 8'hD4, 32'd16);
        rd_chk("R2 rx flushed", 8'hD8, 32'd0);
        seq_push_rx(32'h77);
        rd_chk("R2 rx push dropped", 8'hD8, 32'd0);
        bus_wr(8'h40, 32'd0);
    endtask

    task automatic t_unmapped();
        bus_wr(8'h44, 32'hFFFF_FFFF);
        rd_chk("R9 unmapped reads 0", 8'h44, 32'd0);
        bus_wr(8'h00, 32'd0);
        rd_chk("R9 ident read-only", 8'h00, 32'h0001_0361);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_rooms();
        t_cmd_fill();
        t_tx();
        t_rx();
        t_watermarks();
        t_sync();
        t_soft_reset();
        t_unmapped();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule